// File: doc/BRIEF.md
# Framed Serial Codec Port with Control-Register Readback

This block is the slave end of a framed, full-duplex, synchronous serial link that connects a voice-band codec to a host. Each frame moves one 16-bit word in each direction, most significant bit first. The host marks the first bit with a one-clock frame-sync pulse. A sideband select pin is sampled only in that frame-sync cycle, and it tells the block whether the incoming word is sample data or a control word.

A control word with a clear top bit overwrites the internal control register. A control word with a set top bit belongs to the readback handshake and never changes the register. Bit 14 then separates a request (0) from a go-ahead (1). After a request, the block lets the current transfer finish and waits for the go-ahead. Once the go-ahead arrives, the next outgoing frame carries the register instead of a sample, and the following frames go back to carrying samples. Outgoing samples come from a sample-rate strobe that latches a sample word. Bit 0 of the register drives a dedicated preamplifier-enable output.

Top module: `codec_sport_slave`

## Requirements
- R1: After reset, ctrl_word is 0, preamp_en is 0, rx_valid and rd_done are 0, and transmitted frames carry 0 until a sample is latched.
- R2: A word is sample data when dc_sel is high in its frame-sync cycle. The value of dc_sel in every other cycle of the frame is ignored. At the clock edge that ends the 16th bit of a data word, rx_data takes the word and rx_valid pulses high for one cycle. ctrl_word does not change.
- R3: A control word (dc_sel low at frame sync) with bit 15 = 0 is written in full into ctrl_word at the clock edge that ends its 16th bit.
- R4: A control word with bit 15 = 1 leaves ctrl_word unchanged. If bit 14 = 0 and no readback is under way, it starts a readback (read request).
- R5: While the block waits for the go-ahead, data words are still delivered on rx_data/rx_valid and samples are still transmitted. A control word with bits 15:14 = 11 (read ready) makes the frame after it transmit ctrl_word, as it stands at that frame's sync, in place of a sample.
- R6: A read request that arrives while a readback is under way is ignored. A read-ready word that arrives while no request is pending is ignored. Neither changes ctrl_word or the transmitted word.
- R7: At the clock edge that ends the 16th bit of the register frame, rd_done pulses for one cycle. From the next frame on, the block transmits samples again.
- R8: tx_bit carries the outgoing word MSB first. The MSB is driven in the frame-sync cycle itself. Each outgoing sample is the smp_word most recently latched by smp_strobe. tx_bit is 0 between frames.
- R9: preamp_en always equals bit 0 of ctrl_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync, one cycle, coincides with the first bit |
| dc_sel | input | 1 | High = data word, low = control word; sampled at fsync |
| rx_bit | input | 1 | Serial input data |
| tx_bit | output | 1 | Serial output data |
| smp_strobe | input | 1 | Latches smp_word as the next sample to send |
| smp_word | input | 16 | Sample word from the converter side |
| rx_data | output | 16 | Last received data word |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| ctrl_word | output | 16 | Control register contents |
| preamp_en | output | 1 | Input preamplifier enable (register bit 0) |
| rd_done | output | 1 | One-cycle pulse when the register frame has been sent |

## Verification
The bench goes after several corner cases of the readback order. A data word placed between a request and its go-ahead must still be delivered, and that frame must still carry a sample; a design that shortcuts the handshake would send the register too early. A second request during the wait, and a go-ahead with no request pending, must be ignored; a design that got these wrong would send the register frame at the wrong time or skip it. A register write placed between request and go-ahead must show up in the register frame; a design that captured the register too early would send a stale value. The bench also toggles dc_sel in the middle of frames. A design that sampled it in any cycle other than frame sync would misclassify words and corrupt the register.

// File: rtl/codec_sport_slave.sv
module codec_sport_slave #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fsync,
  input  logic         dc_sel,
  input  logic         rx_bit,
  output logic         tx_bit,
  input  logic         smp_strobe,
  input  logic [W-1:0] smp_word,
  output logic [W-1:0] rx_data,
  output logic         rx_valid,
  output logic [W-1:0] ctrl_word,
  output logic         preamp_en,
  output logic         rd_done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ARMED, ST_OUT} rd_st_t;

  rd_st_t        st;
  logic          active, is_ctrl, last_bit;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rx_sh, tx_sh, smp_buf, word_in, next_tx;

  assign last_bit  = active && (cnt == LAST) && !fsync;
  assign word_in   = {rx_sh[W-2:0], rx_bit};
  assign next_tx   = (st == ST_ARMED) ? ctrl_word : smp_buf;
  assign tx_bit    = fsync ? next_tx[W-1] : tx_sh[W-1];
  assign preamp_en = ctrl_word[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      is_ctrl <= 1'b0;
      rx_sh  <= '0;
      tx_sh  <= '0;
    end else if (fsync) begin
      active  <= 1'b1;
      cnt     <= CW'(1);
      is_ctrl <= ~dc_sel;
      rx_sh   <= {{(W-1){1'b0}}, rx_bit};
      tx_sh   <= {next_tx[W-2:0], 1'b0};
    end else if (active) begin
      rx_sh <= word_in;
      tx_sh <= {tx_sh[W-2:0], 1'b0};
      cnt   <= cnt + CW'(1);
      if (cnt == LAST) active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) smp_buf <= '0;
    else if (smp_strobe) smp_buf <= smp_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= last_bit && !is_ctrl;
      if (last_bit && !is_ctrl) rx_data <= word_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_word <= '0;
    else if (last_bit && is_ctrl && !word_in[W-1]) ctrl_word <= word_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        ST_IDLE:
          if (last_bit && is_ctrl && word_in[W-1] && !word_in[W-2]) st <= ST_WAIT;
        ST_WAIT:
          if (last_bit && is_ctrl && word_in[W-1] && word_in[W-2]) st <= ST_ARMED;
        ST_ARMED:
          if (fsync) st <= ST_OUT;
        default:
          if (last_bit) begin
            st      <= ST_IDLE;
            rd_done <= 1'b1;
          end
      endcase
    end
  end
endmodule

module codec_sport_slave_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fsync,
  input logic         active,
  input logic         last_bit,
  input logic         tx_bit,
  input logic         rx_valid,
  input logic         rd_done,
  input logic [W-1:0] ctrl_word
);
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r2_data_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $stable(ctrl_word));
  a_r3_write_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_word) |-> $past(last_bit));
  a_r7_done_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(last_bit));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  a_r8_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !fsync) |-> !tx_bit);
endmodule

bind codec_sport_slave codec_sport_slave_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .active(active), .last_bit(last_bit),
  .tx_bit(tx_bit), .rx_valid(rx_valid), .rd_done(rd_done), .ctrl_word(ctrl_word)
);

// File: tb/test_codec_sport_slave.sv
module test_codec_sport_slave;
  logic clk = 1'b0, rst_n = 1'b0, fsync = 1'b0, dc_sel = 1'b1, rx_bit = 1'b0;
  logic smp_strobe = 1'b0;
  logic [15:0] smp_word = '0;
  logic tx_bit, rx_valid, preamp_en, rd_done;
  logic [15:0] rx_data, ctrl_word;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] m_ctrl = '0, m_smp = '0;
  int m_st = 0;

  always #4 clk = ~clk;

  codec_sport_slave i_codec_sport_slave (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .dc_sel(dc_sel), .rx_bit(rx_bit),
    .tx_bit(tx_bit), .smp_strobe(smp_strobe), .smp_word(smp_word),
    .rx_data(rx_data), .rx_valid(rx_valid), .ctrl_word(ctrl_word),
    .preamp_en(preamp_en), .rd_done(rd_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic latch_sample(input logic [15:0] v);
    @(negedge clk);
    smp_strobe = 1'b1;
    smp_word = v;
    @(negedge clk);
    smp_strobe = 1'b0;
    m_smp = v;
  endtask

  task automatic frame(input bit dc, input logic [15:0] w, input int gap);
    logic [15:0] got, exp_tx;
    bit exp_done;
    exp_tx = (m_st == 2) ? m_ctrl : m_smp;
    if (m_st == 2) m_st = 3;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      fsync = (i == 0);
      dc_sel = (i == 0) ? dc : 1'($urandom);
      rx_bit = w[15-i];
      #1 got[15-i] = tx_bit;
    end
    @(negedge clk);
    fsync = 1'b0;
    exp_done = 0;
    if (!dc && !w[15]) m_ctrl = w;
    if (m_st == 3) begin
      exp_done = 1;
      m_st = 0;
    end else if (!dc && w[15]) begin
      if (m_st == 0 && !w[14]) m_st = 1;
      else if (m_st == 1 && w[14]) m_st = 2;
    end
    chk(got == exp_tx, (exp_done ? "R5 R7 register frame" : "R8 sample frame"), got, exp_tx);
    chk(rx_valid == dc, "R2 rx_valid", 16'(rx_valid), 16'(dc));
    if (dc) chk(rx_data == w, "R2 rx_data", rx_data, w);
    chk(ctrl_word == m_ctrl, (w[15] ? "R4 R6 ctrl untouched" : "R3 ctrl write"), ctrl_word, m_ctrl);
    chk(preamp_en == m_ctrl[0], "R9 preamp_en", 16'(preamp_en), 16'(m_ctrl[0]));
    chk(rd_done == exp_done, "R7 rd_done", 16'(rd_done), 16'(exp_done));
    for (int g = 1; g < gap; g++) begin
      @(negedge clk);
      chk(!tx_bit && !rx_valid, "R8 R2 idle between frames", {tx_bit, rx_valid}, 16'h0);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_word == 0 && !preamp_en && !rx_valid && !rd_done && !tx_bit,
        "R1 reset state", ctrl_word, 16'h0);
    frame(1'b1, 16'h1234, 3);
    frame(1'b0, 16'h0001, 3);
    latch_sample(16'hA5C3);
    frame(1'b1, 16'hBEEF, 2);
    frame(1'b0, 16'hC0DE, 3);
    frame(1'b1, 16'h0F0F, 3);
    frame(1'b0, 16'h8000, 3);
    frame(1'b1, 16'h5555, 3);
    frame(1'b0, 16'h8123, 3);
    frame(1'b0, 16'h3236, 3);
    latch_sample(16'h7E81);
    frame(1'b0, 16'hC001, 1);
    frame(1'b1, 16'hFFFF, 3);
    frame(1'b1, 16'h0000, 3);
    frame(1'b0, 16'h8001, 3);
    frame(1'b0, 16'hC000, 3);
    frame(1'b1, 16'h1111, 3);
    for (int k = 0; k < 400; k++) begin
      int sel;
      logic [15:0] w;
      bit dc;
      sel = $urandom_range(0, 9);
      w = 16'($urandom);
      dc = 1'b0;
      case (sel)
        0, 1, 2: dc = 1'b1;
        3, 4: w[15] = 1'b0;
        5, 6: w[15:14] = 2'b10;
        default: w[15:14] = 2'b11;
      endcase
      if ($urandom_range(0, 3) == 0) latch_sample(16'($urandom));
      frame(dc, w, $urandom_range(1, 4));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule